// File: doc/BRIEF.md
# Two-wire bus error monitor

This block sits beside a two-wire serial protocol engine and watches the already synchronised clock and data lines for START and STOP conditions. It keeps a count of the bits finished in the current frame, which has nine bit slots: eight address or data bits and one acknowledge bit. When a START or STOP lands inside a frame rather than on a frame boundary, it raises a bus error while the interface takes part in a transfer.

The block owns the status code and the interrupt flag seen by software. A bus error posts code 0x00. A status event from the protocol engine is passed through with its own code. While the flag is clear, the status reads 0xF8, which means nothing to report. Software leaves the error state by setting the stop-request bit and then writing the flag clear. The block then pulses a line-release strobe and an engine reset, and clears the stop-request bit itself. No STOP is placed on the bus during this recovery.

Top module: `twbus_err_mon`

## Requirements
- R1: A START is SDA going 1 to 0 between two samples that both see SCL at 1. A STOP is SDA going 0 to 1 under the same condition. An SDA change while SCL is 0 is neither.
- R2: After a START, the first SCL falling edge (the START's own hold) is not counted. Every later SCL falling edge finishes one bit, and the count wraps after nine bits. A START or STOP seen while 1 to 8 bits of the frame are finished is a bus error. A START or STOP seen with 0 bits finished, including right after a full nine-bit frame, is legal.
- R3: A bus error is raised only while frameActive is 1. With frameActive at 0, the same illegal condition leaves the flag clear.
- R4: A bus error sets irqFlag and makes statusCode read 0x00, both visible after the clock edge that first samples the offending SDA value.
- R5: While irqFlag is 0, statusCode reads 0xF8.
- R6: An engineSet pulse sets irqFlag, and statusCode then reads engineCode. Such a pulse is ignored while a bus error is pending. A bus error in the same cycle takes priority over it.
- R7: With a bus error pending and stopReq at 0, a flagClr pulse is ignored: irqFlag stays 1 and statusCode stays 0x00.
- R8: With a bus error pending and stopReq at 1, a flagClr pulse causes the following changes one edge later. irqFlag and stopReq go to 0 and statusCode reads 0xF8. lineRelease and engineRst are each high for exactly one cycle.
- R9: stopSet sets stopReq and stopDone clears it. A flagClr pulse outside a bus error clears irqFlag and leaves stopReq unchanged.
- R10: After reset, irqFlag, stopReq, lineRelease and engineRst are 0 and statusCode reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Synchronised clock line |
| sdaIn | input | 1 | Synchronised data line |
| frameActive | input | 1 | Interface takes part in the current transfer |
| engineSet | input | 1 | Protocol engine posts a status event |
| engineCode | input | 8 | Status code posted by the engine |
| flagClr | input | 1 | Software writes 1 to the flag |
| stopSet | input | 1 | Software sets the stop-request bit |
| stopDone | input | 1 | Engine clears the stop-request bit |
| statusCode | output | 8 | Current status code |
| irqFlag | output | 1 | Interrupt flag |
| stopReq | output | 1 | Stop-request bit |
| lineRelease | output | 1 | One-cycle strobe that releases both lines |
| engineRst | output | 1 | One-cycle reset to the protocol engine |

## Verification
A START or STOP is recognised at the first edge that samples the new SDA value, with the previous sample held in one register. The flag and the 0x00 code are therefore visible one edge after the changed line is driven. Engine events and flag clears also act one edge after they are presented, and the recovery strobes appear one edge after the clear and drop at the next. The bench drives every input just after a falling clock edge and reads every result after the next falling edge. It checks the one-cycle width of the strobes by reading them at two consecutive falling edges.

// File: rtl/twbus_err_pkg.sv
package twbus_err_pkg;

  localparam int STATUS_W       = 8;
  localparam int BITS_PER_FRAME = 9;
  localparam int BIT_CNT_W      = $clog2(BITS_PER_FRAME);

  localparam logic [STATUS_W-1:0] CODE_BUS_ERR = 8'h00;
  localparam logic [STATUS_W-1:0] CODE_IDLE    = 8'hF8;

  // control -> datapath strobes
  typedef struct packed {
    logic busReset;
  } ctlStrobes_t;

  // datapath -> control events
  typedef struct packed {
    logic startCond;
    logic stopCond;
    logic illegal;
  } busEvt_t;

endpackage

// File: rtl/twbus_err_dp.sv
module twbus_err_dp
  import twbus_err_pkg::*;
#(
  parameter int FRAME_BITS = BITS_PER_FRAME,
  parameter int CNT_W      = BIT_CNT_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        frameActive,
  input  ctlStrobes_t ctl,
  output busEvt_t     evt
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

  logic             sclQ, sdaQ;
  logic             busy;
  logic             holdFall;
  logic [CNT_W-1:0] bitCnt;
  logic             sclFall;
  logic             startNow, stopNow;

  // previous-sample registers for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  always_comb begin
    sclFall  = sclQ && !sclIn;
    startNow = sclQ && sclIn && sdaQ && !sdaIn;
    stopNow  = sclQ && sclIn && !sdaQ && sdaIn;
  end

  // frame position tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      holdFall <= 1'b0;
      bitCnt   <= '0;
    end else if (ctl.busReset) begin
      busy     <= 1'b0;
      holdFall <= 1'b0;
      bitCnt   <= '0;
    end else if (startNow) begin
      busy     <= 1'b1;
      holdFall <= 1'b1;
      bitCnt   <= '0;
    end else if (stopNow) begin
      busy     <= 1'b0;
      holdFall <= 1'b0;
      bitCnt   <= '0;
    end else if (busy && sclFall) begin
      if (holdFall) begin
        holdFall <= 1'b0;
      end else if (bitCnt == LAST_POS) begin
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    evt.startCond = startNow;
    evt.stopCond  = stopNow;
    evt.illegal   = (startNow || stopNow) && busy && (bitCnt != '0) && frameActive;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_POS) else $error("bit counter out of range"); // R2

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> bitCnt == '0) else $error("counter moved while idle"); // R2

  AST_STOP_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (evt.stopCond && !ctl.busReset) |=> !busy) else $error("frame survived STOP"); // R1

  AST_LOW_SCL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !sclIn |-> !(evt.startCond || evt.stopCond)) else $error("condition with SCL low"); // R1

endmodule

// File: rtl/twbus_err_ctl.sv
module twbus_err_ctl
  import twbus_err_pkg::*;
#(
  parameter int SW = STATUS_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  busEvt_t       evt,
  input  logic          engineSet,
  input  logic [SW-1:0] engineCode,
  input  logic          flagClr,
  input  logic          stopSet,
  input  logic          stopDone,
  output ctlStrobes_t   ctl,
  output logic [SW-1:0] statusCode,
  output logic          irqFlag,
  output logic          stopReq,
  output logic          lineRelease,
  output logic          engineRst
);

  logic          errPending;
  logic [SW-1:0] codeReg;
  logic          recoverNow;

  always_comb begin
    recoverNow   = errPending && flagClr && stopReq;
    ctl.busReset = recoverNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPending  <= 1'b0;
      irqFlag     <= 1'b0;
      codeReg     <= CODE_IDLE;
      stopReq     <= 1'b0;
      lineRelease <= 1'b0;
      engineRst   <= 1'b0;
    end else begin
      lineRelease <= 1'b0;
      engineRst   <= 1'b0;
      if (recoverNow) begin
        errPending  <= 1'b0;
        irqFlag     <= 1'b0;
        stopReq     <= 1'b0;
        lineRelease <= 1'b1;
        engineRst   <= 1'b1;
      end else begin
        if (evt.illegal) begin
          errPending <= 1'b1;
          irqFlag    <= 1'b1;
        end else if (engineSet && !errPending) begin
          irqFlag <= 1'b1;
          codeReg <= engineCode;
        end else if (flagClr && !errPending) begin
          irqFlag <= 1'b0;
        end
        if (stopSet) begin
          stopReq <= 1'b1;
        end else if (stopDone) begin
          stopReq <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (!irqFlag)        statusCode = CODE_IDLE;
    else if (errPending) statusCode = CODE_BUS_ERR;
    else                 statusCode = codeReg;
  end

  AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (evt.illegal && !recoverNow) |=> (irqFlag && statusCode == CODE_BUS_ERR))
    else $error("bus error not posted"); // R4

  AST_ENGINE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (errPending && engineSet && !recoverNow) |=> statusCode == CODE_BUS_ERR)
    else $error("engine code overrode error"); // R6

  AST_CLR_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (errPending && flagClr && !stopReq) |=> irqFlag)
    else $error("flag cleared without stop request"); // R7

  AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    lineRelease |=> !lineRelease) else $error("release strobe too long"); // R8

  AST_RECOVERY_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineRelease) |-> (!irqFlag && !stopReq && engineRst))
    else $error("recovery left state behind"); // R8

endmodule

// File: rtl/twbus_err_mon.sv
module twbus_err_mon
  import twbus_err_pkg::*;
#(
  parameter int SW = STATUS_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic          frameActive,
  input  logic          engineSet,
  input  logic [SW-1:0] engineCode,
  input  logic          flagClr,
  input  logic          stopSet,
  input  logic          stopDone,
  output logic [SW-1:0] statusCode,
  output logic          irqFlag,
  output logic          stopReq,
  output logic          lineRelease,
  output logic          engineRst
);

  ctlStrobes_t ctlS;
  busEvt_t     evtS;

  twbus_err_dp #(
    .FRAME_BITS(BITS_PER_FRAME),
    .CNT_W     (BIT_CNT_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .frameActive(frameActive),
    .ctl        (ctlS),
    .evt        (evtS)
  );

  twbus_err_ctl #(
    .SW(SW)
  ) ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evtS),
    .engineSet  (engineSet),
    .engineCode (engineCode),
    .flagClr    (flagClr),
    .stopSet    (stopSet),
    .stopDone   (stopDone),
    .ctl        (ctlS),
    .statusCode (statusCode),
    .irqFlag    (irqFlag),
    .stopReq    (stopReq),
    .lineRelease(lineRelease),
    .engineRst  (engineRst)
  );

endmodule

// File: tb/twbus_err_mon_tb.sv
module twbus_err_mon_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;
  // {isStart, finishedBits[3:0], expectError}
  localparam logic [5:0] VEC [NVEC] = '{
    {1'b1, 4'd0, 1'b0}, {1'b0, 4'd0, 1'b0},
    {1'b1, 4'd1, 1'b1}, {1'b0, 4'd1, 1'b1},
    {1'b1, 4'd2, 1'b1}, {1'b0, 4'd2, 1'b1},
    {1'b1, 4'd3, 1'b1}, {1'b0, 4'd3, 1'b1},
    {1'b1, 4'd4, 1'b1}, {1'b0, 4'd4, 1'b1},
    {1'b1, 4'd5, 1'b1}, {1'b0, 4'd5, 1'b1},
    {1'b1, 4'd6, 1'b1}, {1'b0, 4'd6, 1'b1},
    {1'b1, 4'd7, 1'b1}, {1'b0, 4'd7, 1'b1},
    {1'b1, 4'd8, 1'b1}, {1'b0, 4'd8, 1'b1},
    {1'b1, 4'd9, 1'b0}, {1'b0, 4'd9, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b1, sdaIn = 1'b1, frameActive = 1'b0;
  logic       engineSet = 1'b0, flagClr = 1'b0, stopSet = 1'b0, stopDone = 1'b0;
  logic [7:0] engineCode = 8'h00;
  logic [7:0] statusCode;
  logic       irqFlag, stopReq, lineRelease, engineRst;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twbus_err_mon dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .frameActive(frameActive), .engineSet(engineSet), .engineCode(engineCode),
    .flagClr(flagClr), .stopSet(stopSet), .stopDone(stopDone),
    .statusCode(statusCode), .irqFlag(irqFlag), .stopReq(stopReq),
    .lineRelease(lineRelease), .engineRst(engineRst)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setBus(input logic scl, input logic sda);
    sclIn = scl;
    sdaIn = sda;
    tick();
    tick();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    sclIn = 1'b1; sdaIn = 1'b1; frameActive = 1'b0;
    engineSet = 1'b0; flagClr = 1'b0; stopSet = 1'b0; stopDone = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
  endtask

  // START, then nBits finished bits, then a condition in the next SCL high phase
  task automatic frameThenCond(input int nBits, input logic isStart);
    setBus(1'b1, 1'b1);
    setBus(1'b1, 1'b0);
    setBus(1'b0, 1'b0);
    for (int i = 0; i < nBits; i++) begin
      setBus(1'b0, 1'b1);
      setBus(1'b1, 1'b1);
      setBus(1'b0, 1'b1);
    end
    setBus(1'b0, isStart);
    setBus(1'b1, isStart);
    sclIn = 1'b1;
    sdaIn = !isStart;
    tick();
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    tick();
    sig = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    // R10 reset state
    chk("R10 flag", irqFlag, 0);
    chk("R10 status", statusCode, 8'hF8);
    chk("R10 stopReq", stopReq, 0);
    chk("R10 release", lineRelease, 0);
    chk("R10 engineRst", engineRst, 0);

    // R1 R2 R4 R5 table of positions and conditions
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      frameActive = 1'b1;
      frameThenCond(int'(VEC[v][4:1]), VEC[v][5]);
      chk($sformatf("R2 R4 vec%0d flag", v), irqFlag, VEC[v][0]);
      chk($sformatf("R4 R5 vec%0d status", v), statusCode, VEC[v][0] ? 8'h00 : 8'hF8);
    end

    // R1 SDA change with SCL low mid-frame is not a condition
    doReset();
    frameActive = 1'b1;
    setBus(1'b1, 1'b1); setBus(1'b1, 1'b0); setBus(1'b0, 1'b0);
    setBus(1'b0, 1'b1); setBus(1'b1, 1'b1); setBus(1'b0, 1'b1);
    setBus(1'b0, 1'b0); setBus(1'b0, 1'b1);
    chk("R1 low-SCL toggle", irqFlag, 0);

    // R3 not active -> no error
    doReset();
    frameActive = 1'b0;
    frameThenCond(3, 1'b1);
    chk("R3 inactive flag", irqFlag, 0);
    chk("R3 inactive status", statusCode, 8'hF8);

    // R6 R9 engine pass-through and plain clear
    doReset();
    stopSet = 1'b1; tick(); stopSet = 1'b0;
    chk("R9 stopSet", stopReq, 1);
    engineCode = 8'hA8;
    pulse(engineSet);
    chk("R6 engine flag", irqFlag, 1);
    chk("R6 engine code", statusCode, 8'hA8);
    pulse(flagClr);
    chk("R5 cleared status", statusCode, 8'hF8);
    chk("R9 clear keeps stop", stopReq, 1);
    pulse(stopDone);
    chk("R9 stopDone", stopReq, 0);

    // R6 error wins over same-cycle engine event; engine blocked afterwards
    doReset();
    frameActive = 1'b1;
    engineCode = 8'hB8;
    setBus(1'b1, 1'b1); setBus(1'b1, 1'b0); setBus(1'b0, 1'b0);
    setBus(1'b0, 1'b1); setBus(1'b1, 1'b1); setBus(1'b0, 1'b1);
    setBus(1'b1, 1'b1);
    sdaIn = 1'b0; engineSet = 1'b1;
    tick();
    engineSet = 1'b0;
    chk("R6 same-cycle status", statusCode, 8'h00);
    pulse(engineSet);
    chk("R6 blocked status", statusCode, 8'h00);

    // R7 clear without stop request ignored
    pulse(flagClr);
    chk("R7 flag kept", irqFlag, 1);
    chk("R7 status kept", statusCode, 8'h00);
    chk("R7 no release", lineRelease, 0);

    // R8 recovery
    pulse(stopSet);
    chk("R8 stop armed", stopReq, 1);
    flagClr = 1'b1;
    tick();
    flagClr = 1'b0;
    chk("R8 release high", lineRelease, 1);
    chk("R8 engineRst high", engineRst, 1);
    chk("R8 flag clear", irqFlag, 0);
    chk("R8 stop cleared", stopReq, 0);
    chk("R8 status idle", statusCode, 8'hF8);
    tick();
    chk("R8 release one cycle", lineRelease, 0);
    chk("R8 engineRst one cycle", engineRst, 0);

    // R8 after recovery the engine path works again
    engineCode = 8'hC0;
    pulse(engineSet);
    chk("R8 engine after recovery", statusCode, 8'hC0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule